// File: doc/BRIEF.md
# Three-Lamp Sequential Turn Indicator

This block drives six tail lamps, three on each side of a vehicle. It has three request inputs: turn left, turn right and hazard. A held turn request makes the lamps on that side sweep outward. First the innermost lamp lights, then the inner two, then all three. After that the side goes dark and the sweep starts again. A hazard request flashes all six lamps together: they are all on for one clock and all off for the next.

The controller is a Moore machine with eight states held in a three-bit register, and every code is used. The lamp pattern depends only on the current state. The lamp outputs are registered, loaded from the decode of the next state, so they change only at a clock edge and stay aligned with the state. The clock is assumed to be slow enough to serve directly as the flash rate.

Top module: `tail_sweep`

## Requirements
- R1: A synchronous active-high reset forces the idle state with all six lamps off at the next clock edge. Reset overrides every request input.
- R2: Lamp bit 0 of each side is the innermost lamp and bit 2 is the outermost. A side at sweep level k (0 to 3) drives the thermometer pattern with its k low bits set. The idle state lights nothing. While idle with no request, the lamps stay dark.
- R3: From idle, with the left request held and hazard low, the left lamps step through 001, 011, 111 on successive clocks and then return to 000. The right lamps stay dark throughout.
- R4: The right side mirrors R3 under the right request, and the left lamps stay dark.
- R5: From idle, a hazard request, or left and right requested together, lights all six lamps on the next clock.
- R6: The state with all six lamps lit is always followed by the idle state, whatever the inputs are.
- R7: Hazard asserted in any left or right sweep state aborts the sweep, and all six lamps are lit on the next clock.
- R8: If the active turn request drops during a sweep and hazard is low, the next clock returns to idle with all lamps off.
- R9: During a left sweep the right request has no effect, and during a right sweep the left request has no effect. The sweep continues on its own request.
- R10: Lamps of both sides are lit at the same time only when all six are lit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, also the flash and sweep rate |
| rst | input | 1 | Synchronous active-high reset |
| turn_left | input | 1 | Left turn request |
| turn_right | input | 1 | Right turn request |
| hazard | input | 1 | Hazard flasher request |
| left_lamps | output | LAMPS | Left lamps, bit 0 innermost |
| right_lamps | output | LAMPS | Right lamps, bit 0 innermost |

## Verification
The bench builds the block with its default of three lamps per side. This is the only size at which eight states fill the three-bit register. At that size every transition can be enumerated: the bench reaches each of the eight states by a short request prefix after a reset, applies all eight combinations of the three request inputs, and checks the lamps on the following clock and on one further idle clock. A reset is applied with each combination asserted, so the precedence of reset over hazard and turn requests is covered as well.

// File: rtl/tail_sweep_pkg.sv
package tail_sweep_pkg;

  localparam int unsigned STATE_W = 3;

  // bit 2 picks the right side (or the all-lit state when the level is 0),
  // bits 1:0 carry the sweep level
  typedef enum logic [STATE_W-1:0] {
    ST_DARK  = 3'b000,
    ST_LEFT1 = 3'b001,
    ST_LEFT2 = 3'b010,
    ST_LEFT3 = 3'b011,
    ST_FLASH = 3'b100,
    ST_RGHT1 = 3'b101,
    ST_RGHT2 = 3'b110,
    ST_RGHT3 = 3'b111
  } sweep_st_t;

endpackage

// File: rtl/sweep_next.sv
module sweep_next
  import tail_sweep_pkg::*;
(
  input  sweep_st_t cur,
  input  logic      go_left,
  input  logic      go_right,
  input  logic      haz,
  output sweep_st_t nxt
);

  always_comb begin
    nxt = ST_DARK;
    unique case (cur)
      ST_DARK: begin
        if (haz || (go_left && go_right)) nxt = ST_FLASH;
        else if (go_left)                 nxt = ST_LEFT1;
        else if (go_right)                nxt = ST_RGHT1;
        else                              nxt = ST_DARK;
      end
      ST_LEFT1: nxt = haz ? ST_FLASH : (go_left ? ST_LEFT2 : ST_DARK);
      ST_LEFT2: nxt = haz ? ST_FLASH : (go_left ? ST_LEFT3 : ST_DARK);
      ST_LEFT3: nxt = haz ? ST_FLASH : ST_DARK;
      ST_RGHT1: nxt = haz ? ST_FLASH : (go_right ? ST_RGHT2 : ST_DARK);
      ST_RGHT2: nxt = haz ? ST_FLASH : (go_right ? ST_RGHT3 : ST_DARK);
      ST_RGHT3: nxt = haz ? ST_FLASH : ST_DARK;
      ST_FLASH: nxt = ST_DARK;
      default:  nxt = ST_DARK;
    endcase
  end

endmodule

// File: rtl/sweep_state_reg.sv
module sweep_state_reg
  import tail_sweep_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  sweep_st_t nxt,
  output sweep_st_t cur
);

  always_ff @(posedge clk) begin
    if (rst) cur <= ST_DARK;
    else     cur <= nxt;
  end

endmodule

// File: rtl/lamp_decode.sv
module lamp_decode
  import tail_sweep_pkg::*;
#(
  parameter int unsigned LAMPS = 3
) (
  input  sweep_st_t        st,
  output logic [LAMPS-1:0] left_on,
  output logic [LAMPS-1:0] right_on
);

  localparam int unsigned LW = $clog2(LAMPS + 1);

  logic [LW-1:0] level;
  logic          right_side;
  logic          all_on;

  assign level      = LW'(st[1:0]);
  assign right_side = st[2];
  assign all_on     = (st == ST_FLASH);

  for (genvar i = 0; i < LAMPS; i++) begin : g_lamp
    localparam logic [LW-1:0] THRESH = LW'(i + 1);
    assign left_on[i]  = all_on || (!right_side && (level >= THRESH));
    assign right_on[i] = all_on || ( right_side && (level >= THRESH));
  end

endmodule

// File: rtl/tail_sweep.sv
module tail_sweep
  import tail_sweep_pkg::*;
#(
  parameter int unsigned LAMPS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             turn_left,
  input  logic             turn_right,
  input  logic             hazard,
  output logic [LAMPS-1:0] left_lamps,
  output logic [LAMPS-1:0] right_lamps
);

  sweep_st_t        cur;
  sweep_st_t        nxt;
  logic [LAMPS-1:0] left_d;
  logic [LAMPS-1:0] right_d;

  sweep_next u_next (
    .cur      (cur),
    .go_left  (turn_left),
    .go_right (turn_right),
    .haz      (hazard),
    .nxt      (nxt)
  );

  sweep_state_reg u_state (
    .clk (clk),
    .rst (rst),
    .nxt (nxt),
    .cur (cur)
  );

  // decode the next state so the registered lamps line up with cur
  lamp_decode #(.LAMPS(LAMPS)) u_dec (
    .st       (nxt),
    .left_on  (left_d),
    .right_on (right_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      left_lamps  <= '0;
      right_lamps <= '0;
    end else begin
      left_lamps  <= left_d;
      right_lamps <= right_d;
    end
  end

  a_r1_reset_dark: assert property (@(posedge clk)
    rst |=> (left_lamps == '0 && right_lamps == '0));

  a_r2_dark_state: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_DARK) |-> (left_lamps == '0 && right_lamps == '0));

  a_r3_left_step: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_LEFT1 && turn_left && !hazard) |=> (cur == ST_LEFT2));

  a_r5_idle_flash: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_DARK && (hazard || (turn_left && turn_right)))
      |=> (&left_lamps && &right_lamps));

  a_r6_flash_ends: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_FLASH) |=> (left_lamps == '0 && right_lamps == '0));

  a_r7_hazard_abort: assert property (@(posedge clk) disable iff (rst)
    (cur != ST_DARK && cur != ST_FLASH && hazard) |=> (cur == ST_FLASH));

  a_r8_drop_left: assert property (@(posedge clk) disable iff (rst)
    ((cur == ST_LEFT1 || cur == ST_LEFT2) && !turn_left && !hazard)
      |=> (cur == ST_DARK));

  a_r10_one_side: assert property (@(posedge clk) disable iff (rst)
    ((|left_lamps) && (|right_lamps)) |-> (&left_lamps && &right_lamps));

endmodule

// File: tb/sim_tail_sweep.sv
`timescale 1ns/1ps
module sim_tail_sweep;

  localparam int unsigned LAMPS = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tl = 1'b0, tr = 1'b0, hz = 1'b0;
  logic [LAMPS-1:0] lamps_l, lamps_r;

  int checks = 0;
  int fails  = 0;
  int mst    = 0;   // bench model: 0 idle, 1..3 left, 4..6 right, 7 all lit

  always #10 clk = ~clk;

  tail_sweep #(.LAMPS(LAMPS)) u0 (
    .clk (clk), .rst (rst), .turn_left (tl), .turn_right (tr),
    .hazard (hz), .left_lamps (lamps_l), .right_lamps (lamps_r)
  );

  function automatic int model_next(int s, bit l, bit r, bit h);
    if (s == 7) return 0;
    if (s == 0) begin
      if (h || (l && r)) return 7;
      if (l) return 1;
      if (r) return 4;
      return 0;
    end
    if (h) return 7;
    if (s >= 1 && s <= 3) return (l && s < 3) ? s + 1 : 0;
    return (r && s < 6) ? s + 1 : 0;
  endfunction

  function automatic logic [LAMPS-1:0] exp_left(int s);
    if (s == 7) return '1;
    if (s >= 1 && s <= 3) return LAMPS'((1 << s) - 1);
    return '0;
  endfunction

  function automatic logic [LAMPS-1:0] exp_right(int s);
    if (s == 7) return '1;
    if (s >= 4 && s <= 6) return LAMPS'((1 << (s - 3)) - 1);
    return '0;
  endfunction

  function automatic string tag_for(int s, bit l, bit r, bit h);
    if (s == 7) return "R6";
    if (s == 0) return (h || (l && r)) ? "R5" : (l ? "R3" : (r ? "R4" : "R2"));
    if (h) return "R7";
    if (s <= 3) return !l ? "R8" : (r ? "R9" : "R3");
    return !r ? "R8" : (l ? "R9" : "R4");
  endfunction

  task automatic compare(string tag);
    checks++;
    if (lamps_l !== exp_left(mst) || lamps_r !== exp_right(mst) ||
        ((|lamps_l) && (|lamps_r) && !(&lamps_l && &lamps_r))) begin
      fails++;
      $display("FAIL %s (R10 too) state %0d: got L=%b R=%b expected L=%b R=%b",
               tag, mst, lamps_l, lamps_r, exp_left(mst), exp_right(mst));
    end
  endtask

  // called at a falling edge; applies inputs across one rising edge
  task automatic step(bit l, bit r, bit h);
    string tag;
    tl = l; tr = r; hz = h;
    tag = tag_for(mst, l, r, h);
    @(negedge clk);
    mst = model_next(mst, l, r, h);
    compare(tag);
  endtask

  task automatic do_reset(bit l, bit r, bit h);
    rst = 1'b1; tl = l; tr = r; hz = h;
    @(negedge clk);
    mst = 0;
    compare("R1");
    rst = 1'b0; tl = 0; tr = 0; hz = 0;
  endtask

  initial begin
    #(20.0 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(1, 1, 1);
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 8; c++) begin
        do_reset(c[0], c[1], c[2]);
        if (s >= 1 && s <= 3) for (int k = 0; k < s; k++) step(1, 0, 0);
        if (s >= 4 && s <= 6) for (int k = 0; k < s - 3; k++) step(0, 1, 0);
        if (s == 7) step(0, 0, 1);
        step(c[0], c[1], c[2]);
        step(0, 0, 0);
      end
    end
    // long held requests: two full sweeps each, then a reset mid-sweep (R1)
    do_reset(0, 0, 0);
    for (int k = 0; k < 8; k++) step(1, 0, 0);
    for (int k = 0; k < 8; k++) step(0, 1, 0);
    for (int k = 0; k < 4; k++) step(0, 0, 1);
    step(1, 0, 0);
    step(1, 0, 0);
    do_reset(1, 0, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule